// File: doc/BRIEF.md
# Narrow-to-Wide AXI Read Adapter

This block connects a 64-bit AXI read master to a 256-bit AXI read slave that refuses anything other than full-width transfers. Each read request from the master is an INCR burst of 8-byte beats. The adapter turns it into one INCR burst of 32-byte beats. That burst starts at the 32-byte boundary at or below the master's address and has just enough beats to cover the bytes the master asked for.

On the return path, every 256-bit beat is captured in a holding register. The adapter then presents it to the master one 64-bit lane at a time. It starts at the lane the master's address points to and walks the lanes upward. It raises the last flag only on the final beat of the master's own burst. Both sides may stall at any time. The adapter handles one request at a time and accepts the next one only after the previous burst has fully drained upstream.

Top module: `axi_rd_upsizer`

## Requirements
- R1: Every downstream request carries `m_arsize` = 3'b101 (32 bytes per beat) and `m_arburst` = 2'b01 (INCR).
- R2: `m_araddr` equals the accepted `s_araddr` with its five least significant bits forced to zero.
- R3: `m_arlen` equals (`s_araddr[4:3]` + `s_arlen`) >> 2. `m_arid` equals `s_arid`.
- R4: Upstream beat i carries 64-bit lane ((`s_araddr[4:3]` + i) mod 4) of downstream beat ((`s_araddr[4:3]` + i) div 4). Lane k is bits [64k+63:64k].
- R5: A request returns exactly `s_arlen`+1 upstream beats. `s_rlast` is high on the last of them and low on every other one.
- R6: `s_rresp` and `s_rid` on each upstream beat equal the `m_rresp` and `m_rid` of the downstream beat the data was taken from.
- R7: `m_rready` is low while the held beat still has lanes to send. The exception is the cycle in which lane 3 is accepted upstream and more beats of the burst remain: then `m_rready` is high, so a new beat loads in the same cycle that the old one empties.
- R8: `s_arready` is low from the cycle after a request is accepted until the final upstream beat is accepted. It is high again in the following cycle.
- R9: While `s_rvalid` is high and `s_rready` is low, `s_rvalid`, `s_rdata` and `s_rlast` hold their values into the next cycle.
- R10: While `m_arvalid` is high and `m_arready` is low, `m_arvalid`, `m_araddr` and `m_arlen` hold their values into the next cycle.
- R11: During and right after reset, `s_arready` is high, and `m_arvalid` and `s_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_arvalid | input | 1 | Master read request valid |
| s_arready | output | 1 | Adapter ready for a master request |
| s_araddr | input | ADDR_W | Master start byte address |
| s_arlen | input | 8 | Master burst length minus one (8-byte beats) |
| s_arid | input | ID_W | Master request ID |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Master ready for read data |
| s_rdata | output | UP_W | Upstream 64-bit read data |
| s_rresp | output | 2 | Upstream read response |
| s_rid | output | ID_W | Upstream read ID |
| s_rlast | output | 1 | Final beat of the master burst |
| m_arvalid | output | 1 | Downstream request valid |
| m_arready | input | 1 | Slave ready for a request |
| m_araddr | output | ADDR_W | 32-byte-aligned downstream address |
| m_arlen | output | 8 | Downstream burst length minus one (32-byte beats) |
| m_arsize | output | 3 | Downstream beat size, always 32 bytes |
| m_arburst | output | 2 | Downstream burst type, always INCR |
| m_arid | output | ID_W | Downstream request ID |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Adapter ready for a downstream beat |
| m_rdata | input | DN_W | Downstream 256-bit read data |
| m_rresp | input | 2 | Downstream read response |
| m_rid | input | ID_W | Downstream read ID |

## Verification
Two events can fall in the same cycle: the master accepts lane 3 of the held beat, and the slave hands over the next 256-bit beat. The sweep covers every start lane and burst lengths from one to ten beats. The master's ready follows a stuttering pattern and the slave inserts idle cycles, so lane 3 often lines up with a waiting downstream beat. In each such cycle the bench requires `m_rready` to be high. It then checks that the lanes that follow come from the new beat, with that beat's response code.

// File: rtl/axi_rd_upsizer.sv
module axi_rd_upsizer #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int UP_W   = 64,
  parameter int DN_W   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [7:0]        s_arlen,
  input  logic [ID_W-1:0]   s_arid,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [UP_W-1:0]   s_rdata,
  output logic [1:0]        s_rresp,
  output logic [ID_W-1:0]   s_rid,
  output logic              s_rlast,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DN_W-1:0]   m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic [ID_W-1:0]   m_rid,
  output logic [ID_W-1:0]   m_arid
);

  localparam int LANES = DN_W / UP_W;
  localparam int LW    = $clog2(LANES);
  localparam int UB    = $clog2(UP_W / 8);
  localparam int DB    = $clog2(DN_W / 8);
  localparam logic [ADDR_W-1:0] AMASK = {{(ADDR_W-DB){1'b1}}, {DB{1'b0}}};

  logic              busy, req_pend, have;
  logic [LW-1:0]     lane;
  logic [7:0]        cnt;
  logic [ADDR_W-1:0] ar_addr;
  logic [7:0]        ar_len;
  logic [ID_W-1:0]   ar_id;
  logic [DN_W-1:0]   hold_data;
  logic [1:0]        hold_resp;
  logic [ID_W-1:0]   hold_id;
  logic [8:0]        span;
  logic              ar_take, up_take, dn_take;

  assign span    = 9'(s_araddr[DB-1:UB]) + 9'(s_arlen);
  assign ar_take = s_arvalid & ~busy;
  assign up_take = have & s_rready;
  assign dn_take = m_rvalid & m_rready;

  assign s_arready = ~busy;
  assign m_arvalid = req_pend;
  assign m_araddr  = ar_addr;
  assign m_arlen   = ar_len;
  assign m_arid    = ar_id;
  assign m_arsize  = 3'(DB);
  assign m_arburst = 2'b01;

  assign m_rready  = busy & (~have | (up_take & (&lane) & (cnt != 8'd0)));

  assign s_rvalid  = have;
  assign s_rdata   = hold_data[lane*UP_W +: UP_W];
  assign s_rresp   = hold_resp;
  assign s_rid     = hold_id;
  assign s_rlast   = have & (cnt == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      req_pend <= 1'b0;
      have     <= 1'b0;
      lane     <= '0;
      cnt      <= '0;
      ar_addr  <= '0;
      ar_len   <= '0;
      ar_id    <= '0;
    end else begin
      if (ar_take) begin
        busy     <= 1'b1;
        req_pend <= 1'b1;
        ar_addr  <= s_araddr & AMASK;
        ar_len   <= 8'(span >> LW);
        ar_id    <= s_arid;
        cnt      <= s_arlen;
        lane     <= s_araddr[DB-1:UB];
      end
      if (req_pend && m_arready) req_pend <= 1'b0;
      if (up_take) begin
        if (cnt == 8'd0) begin
          busy <= 1'b0;
          have <= 1'b0;
        end else begin
          cnt  <= cnt - 8'd1;
          lane <= lane + 1'b1;
          if (&lane) have <= 1'b0;
        end
      end
      if (dn_take) have <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (dn_take) begin
      hold_data <= m_rdata;
      hold_resp <= m_rresp;
      hold_id   <= m_rid;
    end
  end

endmodule

// File: rtl/axi_rd_upsizer_chk.sv
module axi_rd_upsizer_chk #(
  parameter int ADDR_W = 32,
  parameter int UP_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_arready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [UP_W-1:0]   s_rdata,
  input logic              s_rlast,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic              m_rready
);

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> m_araddr[4:0] == 5'd0);

  p_no_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |-> !m_rready);

  p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid || m_arvalid) |-> !s_arready);

  p_up_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rlast)));

  p_ar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));

endmodule

bind axi_rd_upsizer axi_rd_upsizer_chk #(.ADDR_W(ADDR_W), .UP_W(UP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_arready(s_arready), .s_rvalid(s_rvalid),
  .s_rready(s_rready), .s_rdata(s_rdata), .s_rlast(s_rlast),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_arlen(m_arlen), .m_rready(m_rready)
);

// File: tb/axi_rd_upsizer_tb.sv
module axi_rd_upsizer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_arvalid = 0, s_arready, s_rvalid, s_rready = 0, s_rlast;
  logic [31:0] s_araddr = 0;
  logic [7:0] s_arlen = 0;
  logic [3:0] s_arid = 0, s_rid, m_arid, m_rid = 0;
  logic [63:0] s_rdata;
  logic [1:0] s_rresp, m_arburst, m_rresp = 0;
  logic m_arvalid, m_arready = 0, m_rvalid = 0, m_rready;
  logic [31:0] m_araddr;
  logic [7:0] m_arlen;
  logic [2:0] m_arsize;
  logic [255:0] m_rdata = 0;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_addr;
  int exp_len;
  logic [3:0] exp_id;

  axi_rd_upsizer dut_i (
    .clk(clk), .rst_n(rst_n), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_araddr(s_araddr), .s_arlen(s_arlen), .s_arid(s_arid), .s_rvalid(s_rvalid),
    .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rid(s_rid),
    .s_rlast(s_rlast), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rid(m_rid), .m_arid(m_arid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word8(input logic [31:0] a);
    return {a ^ 32'hC0DE0000, ~a};
  endfunction

  function automatic logic [255:0] dn_beat(input logic [31:0] base);
    logic [255:0] d;
    for (int k = 0; k < 4; k++) d[64*k +: 64] = word8(base + 32'(8*k));
    return d;
  endfunction

  // downstream slave model
  initial begin
    logic [31:0] base;
    int n;
    logic [3:0] id;
    bit got;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      m_arready = (cyc % 3) != 1;
      #2;
      if (m_arvalid && m_arready) begin
        chk(m_arsize == 3'b101 && m_arburst == 2'b01, "R1 size/burst",
            {m_arsize, m_arburst}, {3'b101, 2'b01});
        chk(m_araddr == (exp_addr & ~32'd31), "R2 addr", m_araddr, exp_addr & ~32'd31);
        chk(m_arlen == 8'((exp_addr[4:3] + exp_len) >> 2), "R3 len",
            m_arlen, 8'((exp_addr[4:3] + exp_len) >> 2));
        chk(m_arid == exp_id, "R3 id", m_arid, exp_id);
        base = m_araddr; n = m_arlen; id = m_arid;
        @(negedge clk);
        m_arready = 0;
        for (int b = 0; b <= n; b++) begin
          if (cyc % 4 == 0) begin
            m_rvalid = 0;
            @(negedge clk);
          end
          m_rvalid = 1;
          m_rdata = dn_beat(base + 32'(32*b));
          m_rresp = 2'(b);
          m_rid = id;
          do begin
            #2 got = m_rready;
            @(negedge clk);
          end while (!got);
          m_rvalid = 0;
        end
      end
    end
  end

  task automatic run_txn(input logic [31:0] addr, input int len, input logic [3:0] id, input int mode);
    int lane0, i, ln;
    bit ok, stall;
    logic [63:0] sdata;
    logic [31:0] wa;
    lane0 = int'(addr[4:3]);
    exp_addr = addr; exp_len = len; exp_id = id;
    @(negedge clk);
    s_arvalid = 1; s_araddr = addr; s_arlen = 8'(len); s_arid = id;
    do begin
      #2 ok = s_arready;
      @(negedge clk);
    end while (!ok);
    s_arvalid = 0;
    i = 0; stall = 0; sdata = 0;
    while (i <= len) begin
      s_rready = (mode == 0) ? 1'b1 : ((cyc % 5) != 2 && (cyc % 7) != 3);
      #2;
      chk(!s_arready, "R8 busy", {63'd0, s_arready}, 64'd0);
      if (stall) begin
        chk(s_rvalid && s_rdata == sdata, "R9 hold", s_rdata, sdata);
      end
      stall = 0;
      if (s_rvalid) begin
        ln = (lane0 + i) % 4;
        if (s_rready && ln == 3 && i != len) begin
          if (m_rvalid) chk(m_rready, "R7 overlap load", {63'd0, m_rready}, 64'd1);
        end else begin
          chk(!m_rready, "R7 no refill", {63'd0, m_rready}, 64'd0);
        end
        if (s_rready) begin
          wa = (addr & ~32'd7) + 32'(8*i);
          chk(s_rdata == word8(wa), "R4 lane data", s_rdata, word8(wa));
          chk(s_rlast == (i == len), "R5 last", {63'd0, s_rlast}, {63'd0, i == len});
          chk(s_rresp == 2'((lane0 + i) / 4) && s_rid == id, "R6 resp/id",
              {s_rresp, s_rid}, {2'((lane0 + i) / 4), id});
          i++;
        end else begin
          stall = 1;
          sdata = s_rdata;
        end
      end
      @(negedge clk);
    end
    s_rready = 0;
    #2;
    chk(s_arready && !s_rvalid, "R8/R5 release", {s_arready, s_rvalid}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int run;
    repeat (3) @(negedge clk);
    chk(s_arready && !m_arvalid && !s_rvalid, "R11 in reset",
        {s_arready, m_arvalid, s_rvalid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(s_arready && !m_arvalid && !s_rvalid, "R11 after reset",
        {s_arready, m_arvalid, s_rvalid}, 3'b100);
    run = 0;
    for (int mode = 0; mode < 2; mode++)
      for (int ln = 0; ln < 4; ln++)
        for (int len = 0; len < 10; len++) begin
          run_txn(32'h2000 + 32'(run * 512) + 32'(ln * 8) + ((len % 3 == 2) ? 32'd3 : 32'd0),
                  len, 4'(run), mode);
          run++;
        end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule